// File: doc/BRIEF.md
# Random Byte Register Block

This block puts a random-byte source on a simple memory-mapped bus as three byte-wide registers: a control/status register, a data register and a mode register. An external entropy source offers bytes through a valid/ready handshake. Software turns the block on by setting the enable bit and writing the run code into the mode register. Reading the status register while the block is on and holds no byte pulls in a fresh byte and raises the data-valid flag. Reading the data register then hands that byte out, zeroes it and drops the flag.

The bus takes one request per cycle, made up of address, write enable and write data. Read data is registered and appears one cycle after the request. Every side effect of a read is applied on the same clock edge. Registers sit in the low byte of a 32-bit word, and the upper bits of read data are always zero.

Top module: `entropy_byte_regs`

## Requirements
- R1: After reset the status, data and mode registers all read as zero, and the entropy ready output is low.
- R2: Only the word offsets 0x00 (status), 0x04 (data) and 0x08 (mode) decode. Any other offset, including unaligned ones, reads zero and ignores writes. Read data appears the cycle after the request and is zero after a cycle with no read request.
- R3: In the status register, bit 0 is the enable bit and bit 1 is the data-valid flag. Bits 5:2 are a prescaler field that is only stored and read back, and bits 7:6 are stored as well. A status write takes every bit from the write data except bit 1, which keeps its old value.
- R4: The block is enabled only when the enable bit is 1 and the mode register holds exactly 0x02.
- R5: A status read while the block is disabled clears the data-valid flag, and the returned value already shows it cleared.
- R6: A status read while the block is enabled and data-valid is clear raises entropy ready in that cycle. If the source offers a byte, that byte is stored, data-valid is set, and the returned value already shows bit 1 set.
- R7: If the source offers no byte during such a read, data-valid stays clear and the returned value shows it clear.
- R8: A data read while the block is enabled and data-valid is set returns the stored byte, clears data-valid and sets the stored byte to zero.
- R9: A data read in any other state returns zero and changes no state.
- R10: The data register is read-only. The mode register takes the low byte of a write and reads back as written.
- R11: Entropy ready is asserted only during a status read while the block is enabled and empty, so no byte is taken at any other time.
- R12: Read data bits 31:8 are always zero, and write data bits 31:8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request in this cycle |
| busWrite | input | 1 | 1 = write request, 0 = read request |
| busAddr | input | 12 | Byte offset inside the 4 KiB window |
| busWdata | input | 32 | Write data, register in low byte |
| busRdata | output | 32 | Registered read data, one cycle after the request |
| srcValid | input | 1 | Entropy source offers a byte |
| srcData | input | 8 | Offered entropy byte |
| srcReady | output | 1 | Block takes the offered byte this cycle |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 32-bit bus, 8-bit registers and run code 0x02. With these values it can reach unaligned and out-of-map offsets and check the zero upper bits of read data. It also exercises mode values next to the run code (0x03, 0x06), which must keep the block disabled. The entropy port offers a different fixed byte at each step, so the byte that later comes out of the data register shows exactly which handshake cycle captured it.

// File: rtl/entropy_pkg.sv
package entropy_pkg;

  localparam int ENABLE_BIT = 0;
  localparam int VALID_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CS   = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MODE = 2'd3
  } rdSel_e;

  // Strobes from control to datapath, one cycle's worth of register actions
  typedef struct packed {
    logic   csWrite;
    logic   modeWrite;
    logic   capture;
    logic   dropValid;
    logic   consume;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/entropy_ctrl.sv
module entropy_ctrl
  import entropy_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              REG_W    = 8,
  parameter logic [ADDR_W-1:0] OFF_CS   = 'h000,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h004,
  parameter logic [ADDR_W-1:0] OFF_MODE = 'h008,
  parameter logic [REG_W-1:0]  RUN_MODE = 'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              srcValid,
  input  logic [REG_W-1:0]  csQ,
  input  logic [REG_W-1:0]  modeQ,
  output regStrobe_t        strobe,
  output logic              srcReady
);

  logic hitCs, hitData, hitMode;
  logic rdReq, wrReq, csRead, isEnabled;

  assign hitCs   = (busAddr == OFF_CS);
  assign hitData = (busAddr == OFF_DATA);
  assign hitMode = (busAddr == OFF_MODE);
  assign rdReq   = busValid && !busWrite;
  assign wrReq   = busValid && busWrite;
  assign csRead  = rdReq && hitCs;

  assign isEnabled = csQ[ENABLE_BIT] && (modeQ == RUN_MODE);

  assign srcReady = csRead && isEnabled && !csQ[VALID_BIT];

  always_comb begin
    strobe.csWrite   = wrReq && hitCs;
    strobe.modeWrite = wrReq && hitMode;
    strobe.capture   = srcReady && srcValid;
    strobe.dropValid = csRead && !isEnabled;
    strobe.consume   = rdReq && hitData && isEnabled && csQ[VALID_BIT];
    if (!rdReq)       strobe.rdSel = SEL_NONE;
    else if (hitCs)   strobe.rdSel = SEL_CS;
    else if (hitData) strobe.rdSel = SEL_DATA;
    else if (hitMode) strobe.rdSel = SEL_MODE;
    else              strobe.rdSel = SEL_NONE;
  end

  // R4: a mode other than the run code blocks both handshake and consumption
  p_mode_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != RUN_MODE) |-> (!srcReady && !strobe.consume));

  // R11: the handshake only opens during a status read
  p_ready_on_cs_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> (strobe.rdSel == SEL_CS));

endmodule

// File: rtl/entropy_datapath.sv
module entropy_datapath
  import entropy_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] wrByte,
  input  logic [REG_W-1:0] srcData,
  output logic [REG_W-1:0] csQ,
  output logic [REG_W-1:0] modeQ,
  output logic [BUS_W-1:0] busRdata
);

  logic [REG_W-1:0] dataQ;
  logic [REG_W-1:0] csNext;
  logic [REG_W-1:0] rdByte;
  logic [BUS_W-1:0] rdataQ;

  always_comb begin
    csNext = csQ;
    if (strobe.csWrite) begin
      csNext = wrByte;
      csNext[VALID_BIT] = csQ[VALID_BIT];
    end
    if (strobe.capture)   csNext[VALID_BIT] = 1'b1;
    if (strobe.dropValid) csNext[VALID_BIT] = 1'b0;
    if (strobe.consume)   csNext[VALID_BIT] = 1'b0;
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_CS:   rdByte = csNext;
      SEL_DATA: rdByte = strobe.consume ? dataQ : '0;
      SEL_MODE: rdByte = modeQ;
      default:  rdByte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ    <= '0;
      dataQ  <= '0;
      modeQ  <= '0;
      rdataQ <= '0;
    end else begin
      csQ <= csNext;
      if (strobe.capture)      dataQ <= srcData;
      else if (strobe.consume) dataQ <= '0;
      if (strobe.modeWrite)    modeQ <= wrByte;
      rdataQ <= BUS_W'(rdByte);
    end
  end

  generate
    if (BUS_W > REG_W) begin : g_pad
      assign busRdata = {{(BUS_W-REG_W){1'b0}}, rdataQ[REG_W-1:0]};
      logic unusedRdHi;
      assign unusedRdHi = ^rdataQ[BUS_W-1:REG_W];
    end else begin : g_flat
      assign busRdata = rdataQ;
    end
  endgenerate

  // R6: a captured byte is held and flagged on the next cycle
  p_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (csQ[VALID_BIT] && dataQ == $past(srcData)
                        && busRdata[VALID_BIT]));

  // R6: data-valid only rises through a capture
  p_valid_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csQ[VALID_BIT]) |-> $past(strobe.capture));

  // R8: consuming returns the byte and empties the register
  p_consume_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.consume |=> (!csQ[VALID_BIT] && dataQ == '0
                        && busRdata == BUS_W'($past(dataQ))));

  // R3: a bus write cannot move data-valid
  p_keep_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.csWrite |=> (csQ[VALID_BIT] == $past(csQ[VALID_BIT])));

  // R5: a disabled status read returns and leaves the flag clear
  p_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropValid |=> (!csQ[VALID_BIT] && !busRdata[VALID_BIT]));

  // R2: read data is zero after a cycle with no decoded read
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_NONE) |=> (busRdata == '0));

endmodule

// File: rtl/entropy_byte_regs.sv
module entropy_byte_regs
  import entropy_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 32,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] OFF_CS   = 'h000,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h004,
  parameter logic [ADDR_W-1:0] OFF_MODE = 'h008,
  parameter logic [REG_W-1:0]  RUN_MODE = 'h02
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              srcValid,
  input  logic [REG_W-1:0]  srcData,
  output logic              srcReady
);

  regStrobe_t       strobe;
  logic [REG_W-1:0] csQ;
  logic [REG_W-1:0] modeQ;
  logic [REG_W-1:0] wrByte;

  assign wrByte = busWdata[REG_W-1:0];

  generate
    if (BUS_W > REG_W) begin : g_wd_hi
      logic unusedWdHi;
      assign unusedWdHi = ^busWdata[BUS_W-1:REG_W];
    end
  endgenerate

  entropy_ctrl #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .OFF_CS(OFF_CS),
    .OFF_DATA(OFF_DATA), .OFF_MODE(OFF_MODE), .RUN_MODE(RUN_MODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .srcValid(srcValid), .csQ(csQ), .modeQ(modeQ),
    .strobe(strobe), .srcReady(srcReady)
  );

  entropy_datapath #(
    .BUS_W(BUS_W), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(wrByte),
    .srcData(srcData), .csQ(csQ), .modeQ(modeQ), .busRdata(busRdata)
  );

  // R12: upper read-data bits stay zero
  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_W-1:REG_W] == '0);

endmodule

// File: tb/tb_entropy_byte_regs.sv
module tb_entropy_byte_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        srcValid = 1'b0;
  logic [7:0]  srcData = '0;
  logic        srcReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  entropy_byte_regs dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady)
  );

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic        sv;
    logic [7:0]  sd;
    logic [31:0] ex;
    logic        rdy;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd1},  // R1
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd1},  // R1
    '{1'b0, 12'h008, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd1},  // R1
    '{1'b1, 12'h008, 32'h03,       1'b0, 8'h00, 32'h00, 1'b0, 8'd10}, // R10
    '{1'b1, 12'h000, 32'hFFFFFF3F, 1'b0, 8'h00, 32'h00, 1'b0, 8'd3},  // R3
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'hA5, 32'h3D, 1'b0, 8'd4},  // R4
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd9},  // R9
    '{1'b1, 12'h008, 32'h02,       1'b0, 8'h00, 32'h00, 1'b0, 8'd10}, // R10
    '{1'b0, 12'h008, 32'h0,        1'b0, 8'h00, 32'h02, 1'b0, 8'd10}, // R10
    '{1'b0, 12'h000, 32'h0,        1'b0, 8'h00, 32'h3D, 1'b1, 8'd7},  // R7
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd9},  // R9
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'hA5, 32'h3F, 1'b1, 8'd6},  // R6
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'h11, 32'h3F, 1'b0, 8'd11}, // R11
    '{1'b1, 12'h004, 32'hFF,       1'b0, 8'h00, 32'h00, 1'b0, 8'd10}, // R10
    '{1'b1, 12'h000, 32'hC0,       1'b0, 8'h00, 32'h00, 1'b0, 8'd3},  // R3
    '{1'b1, 12'h000, 32'h01,       1'b0, 8'h00, 32'h00, 1'b0, 8'd3},  // R3
    '{1'b0, 12'h004, 32'h0,        1'b1, 8'h44, 32'hA5, 1'b0, 8'd8},  // R8
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd8},  // R8
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'h5A, 32'h03, 1'b1, 8'd6},  // R6
    '{1'b1, 12'h008, 32'h06,       1'b0, 8'h00, 32'h00, 1'b0, 8'd4},  // R4
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'h33, 32'h01, 1'b0, 8'd5},  // R5
    '{1'b1, 12'h008, 32'hABCDEF02, 1'b0, 8'h00, 32'h00, 1'b0, 8'd12}, // R12
    '{1'b0, 12'h008, 32'h0,        1'b0, 8'h00, 32'h02, 1'b0, 8'd12}, // R12
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd5},  // R5
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'h77, 32'h03, 1'b1, 8'd6},  // R6
    '{1'b1, 12'h000, 32'h00,       1'b0, 8'h00, 32'h00, 1'b0, 8'd9},  // R9
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd9},  // R9
    '{1'b1, 12'h000, 32'h01,       1'b0, 8'h00, 32'h00, 1'b0, 8'd9},  // R9
    '{1'b0, 12'h004, 32'h0,        1'b0, 8'h00, 32'h77, 1'b0, 8'd9},  // R9
    '{1'b0, 12'h00C, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd2},  // R2
    '{1'b1, 12'h00C, 32'hFF,       1'b0, 8'h00, 32'h00, 1'b0, 8'd2},  // R2
    '{1'b1, 12'h010, 32'hFF,       1'b0, 8'h00, 32'h00, 1'b0, 8'd2},  // R2
    '{1'b0, 12'h001, 32'h0,        1'b0, 8'h00, 32'h00, 1'b0, 8'd2},  // R2
    '{1'b0, 12'h008, 32'h0,        1'b0, 8'h00, 32'h02, 1'b0, 8'd2},  // R2
    '{1'b0, 12'h000, 32'h0,        1'b0, 8'h00, 32'h01, 1'b1, 8'd7},  // R7
    '{1'b1, 12'h000, 32'hC0,       1'b0, 8'h00, 32'h00, 1'b0, 8'd3},  // R3
    '{1'b1, 12'h000, 32'h02,       1'b0, 8'h00, 32'h00, 1'b0, 8'd3},  // R3
    '{1'b0, 12'h000, 32'h0,        1'b1, 8'h99, 32'h00, 1'b0, 8'd3}   // R3
  };

  task automatic check(input string what, input int req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bus request: ready checked before the edge, read data after it
  task automatic op(input logic we, input logic [11:0] a, input logic [31:0] wd,
                    input logic sv, input logic [7:0] sd, input logic [31:0] ex,
                    input logic rdy, input int req);
    busValid = 1'b1;
    busWrite = we;
    busAddr  = a;
    busWdata = wd;
    srcValid = sv;
    srcData  = sd;
    #2;
    check("srcReady", req, {31'b0, srcReady}, {31'b0, rdy});
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0;
    srcValid = 1'b0;
    check("busRdata", req, busRdata, ex);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(VECS[i].we, VECS[i].addr, VECS[i].wd, VECS[i].sv, VECS[i].sd,
         VECS[i].ex, VECS[i].rdy, int'(VECS[i].req));
    end

    // R2: an idle cycle after a read leaves read data at zero
    op(1'b0, 12'h008, 32'h0, 1'b0, 8'h00, 32'h02, 1'b0, 10);
    @(negedge clk);
    check("idle rdata", 2, busRdata, 32'h0);

    // R1: load state, then reset and confirm everything returns to zero
    op(1'b1, 12'h000, 32'h3D, 1'b0, 8'h00, 32'h00, 1'b0, 3);
    op(1'b0, 12'h000, 32'h0, 1'b1, 8'h99, 32'h3F, 1'b1, 6);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    op(1'b0, 12'h000, 32'h0, 1'b1, 8'h12, 32'h00, 1'b0, 1);
    op(1'b0, 12'h004, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 1);
    op(1'b0, 12'h008, 32'h0, 1'b0, 8'h00, 32'h00, 1'b0, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule